// File: doc/BRIEF.md
# Two-Requester Atomic Test-and-Set Lock

This block is a one-bit lock shared by two requesters. Each requester owns a port on which it can send one of two operations. The first is test-and-set, which returns the bit's prior value and leaves the bit at 1. The second is clear, which returns the prior value and leaves the bit at 0. Each operation completes in one indivisible step. When both ports send an operation in the same cycle, the block applies them in a fixed order within that cycle. Port 0 goes first and port 1 then sees the value that port 0 left. Each port's response agrees with that order. Of two test-and-sets racing on a free lock, exactly one therefore wins.

Each port also holds an acquire/release sequencer. A pulse on its acquire input starts test-and-set attempts. Between failed attempts the sequencer waits a programmable number of idle cycles. Once an attempt returns 0, the sequencer holds its critical indication until told to leave. On leaving, it sends a clear and drops back to idle. While a sequencer is sending an operation, it owns its port's access to the lock bit. A direct operation offered on that port in the same cycle is dropped.

Top module: `tas_lock_pair`

## Requirements
- R1: While rst_n is low at a clock edge, the lock bit goes to 0, every response valid goes to 0 and both sequencers return to idle (busy and critical low). This also holds when reset arrives while a sequencer holds the lock.
- R2: A direct test-and-set (op_kind_i bit = 0) returns the lock's prior value in rsp_old_o. The lock reads 1 afterwards.
- R3: A direct clear (op_kind_i bit = 1) returns the lock's prior value in rsp_old_o. The lock reads 0 afterwards.
- R4: An accepted direct request at a clock edge gives rsp_vld_o high for exactly the following cycle on that port. Without such a request, rsp_vld_o stays low.
- R5: Two test-and-sets in the same cycle on a free lock return 0 on port 0 and 1 on port 1.
- R6: Same-cycle operations take effect port 0 first and then port 1. Port 1's returned value is the lock as port 0 left it. The final lock value is port 1's result.
- R7: An acquire pulse on an idle sequencer raises seq_busy_o at the next edge. On a free lock, seq_crit_o rises at the third edge after the pulse.
- R8: While the lock is held, a trying sequencer stays busy and not critical, and retries with RETRY_GAP idle cycles between attempts. It becomes critical within RETRY_GAP+3 edges after the lock is cleared.
- R9: A leave pulse while critical drops seq_crit_o at the next edge. The lock reads 0 and seq_busy_o is low one edge later.
- R10: A direct operation offered on a port in a cycle where that port's sequencer sends an operation is ignored: no response pulse and no change to the lock.
- R11: The two sequencers are never critical in the same cycle. If both start on a free lock in the same cycle, port 0's sequencer enters first and port 1's enters after port 0 leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_vld_i | input | 2 | Direct operation request, one bit per port |
| op_kind_i | input | 2 | Per-port operation: 0 test-and-set, 1 clear |
| rsp_vld_o | output | 2 | Per-port response pulse, one cycle after the request |
| rsp_old_o | output | 2 | Per-port lock value before the operation |
| seq_want_i | input | 2 | Per-port acquire pulse to the sequencer |
| seq_done_i | input | 2 | Per-port leave pulse to the sequencer |
| seq_busy_o | output | 2 | Sequencer is not idle |
| seq_crit_o | output | 2 | Sequencer holds the lock |
| lock_o | output | 1 | Current lock bit |

## Verification
The bench builds the block with RETRY_GAP = 2. This value puts a real backoff wait between failed attempts, so a lock cleared during a wait, or during an attempt, shows the worst-case delay before the next win. With this value the losing sequencer in a same-cycle start is still backing off when the winner releases. This tests the hand-over without both sequencers being critical together.

// File: rtl/tas_lock_pkg.sv
// Shared definitions for the two-port test-and-set lock.
// Assumes exactly two ports; the serial order follows port index.
package tas_lock_pkg;
    localparam int NPORT = 2;

    typedef enum logic {
        OP_TAS = 1'b0,
        OP_CLR = 1'b1
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_TRY  = 3'd1,
        SQ_WAIT = 3'd2,
        SQ_BACK = 3'd3,
        SQ_CRIT = 3'd4,
        SQ_REL  = 3'd5
    } seq_state_e;
endpackage

// File: rtl/tas_lock_core.sv
// Lock bit with same-cycle serialization of all port operations.
// Port index sets the order: lower index applied first. Each port's
// returned value is the bit as the ports before it left it.
// Assumes req_kind is meaningful only where req_vld is high.
module tas_lock_core
    import tas_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req_vld,
    input  logic [NPORT-1:0] req_kind,
    output logic             lock_o,
    output logic [NPORT-1:0] rsp_vld,
    output logic [NPORT-1:0] rsp_old
);
    logic             lock_q;
    logic [NPORT:0]   chain;
    logic [NPORT-1:0] old_c;

    // Walk the ports in order, each seeing the previous one's result.
    always_comb begin
        chain[0] = lock_q;
        for (int p = 0; p < NPORT; p++) begin
            old_c[p] = chain[p];
            if (req_vld[p]) begin
                chain[p+1] = (req_kind[p] == OP_CLR) ? 1'b0 : 1'b1;
            end else begin
                chain[p+1] = chain[p];
            end
        end
    end

    // Commit the final value and register per-port responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            rsp_vld <= '0;
            rsp_old <= '0;
        end else begin
            lock_q  <= chain[NPORT];
            rsp_vld <= req_vld;
            rsp_old <= old_c;
        end
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/tas_lock_portsel.sv
// Per-port selector between the sequencer and the direct request.
// The sequencer wins the port whenever it sends; a direct request in
// that cycle is dropped. The response is routed back to whichever
// source sent the request, using a one-bit record of the source.
module tas_lock_portsel (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_vld,
    input  logic dir_kind,
    input  logic seq_vld,
    input  logic seq_kind,
    input  logic core_rsp_vld,
    input  logic core_rsp_old,
    output logic core_vld,
    output logic core_kind,
    output logic rsp_vld_o,
    output logic rsp_old_o,
    output logic seq_rsp_vld,
    output logic seq_rsp_old
);
    logic from_seq_q;

    // Choose the request source for this cycle.
    always_comb begin
        core_vld  = seq_vld | dir_vld;
        core_kind = seq_vld ? seq_kind : dir_kind;
    end

    // Remember who sent the request so the response goes back to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_seq_q <= 1'b0;
        end else begin
            from_seq_q <= seq_vld;
        end
    end

    // Split the response between the direct port and the sequencer.
    always_comb begin
        rsp_vld_o   = core_rsp_vld & ~from_seq_q;
        rsp_old_o   = core_rsp_old & ~from_seq_q;
        seq_rsp_vld = core_rsp_vld & from_seq_q;
        seq_rsp_old = core_rsp_old & from_seq_q;
    end
endmodule

// File: rtl/tas_lock_seq.sv
// Acquire/release sequencer for one port.
// Idle until want_i; then sends test-and-set, waits for the response,
// and either enters the critical state (value 0) or backs off
// RETRY_GAP cycles and retries. done_i in the critical state sends a
// clear and returns to idle. Assumes a response one cycle after issue.
module tas_lock_seq
    import tas_lock_pkg::*;
#(
    parameter int RETRY_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic done_i,
    input  logic rsp_vld_i,
    input  logic rsp_old_i,
    output logic op_vld_o,
    output logic op_kind_o,
    output logic busy_o,
    output logic crit_o
);
    localparam int CW = (RETRY_GAP > 1) ? $clog2(RETRY_GAP) : 1;
    localparam logic [CW-1:0] LOAD = CW'((RETRY_GAP > 0) ? RETRY_GAP - 1 : 0);

    seq_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // Next-state and backoff counter logic.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        case (state_q)
            SQ_IDLE: if (want_i) state_n = SQ_TRY;
            SQ_TRY:  state_n = SQ_WAIT;
            SQ_WAIT: begin
                if (rsp_vld_i) begin
                    if (!rsp_old_i) begin
                        state_n = SQ_CRIT;
                    end else if (RETRY_GAP == 0) begin
                        state_n = SQ_TRY;
                    end else begin
                        state_n = SQ_BACK;
                        cnt_n   = LOAD;
                    end
                end
            end
            SQ_BACK: begin
                if (cnt_q == '0) begin
                    state_n = SQ_TRY;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            SQ_CRIT: if (done_i) state_n = SQ_REL;
            SQ_REL:  state_n = SQ_IDLE;
            default: state_n = SQ_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Operation requests and status outputs decoded from the state.
    always_comb begin
        op_vld_o  = (state_q == SQ_TRY) || (state_q == SQ_REL);
        op_kind_o = (state_q == SQ_REL) ? OP_CLR : OP_TAS;
        busy_o    = (state_q != SQ_IDLE);
        crit_o    = (state_q == SQ_CRIT);
    end
endmodule

// File: rtl/tas_lock_pair.sv
// Top: two-port test-and-set lock with one sequencer per port.
// Each port has a direct operation interface and a sequencer sharing
// it (the sequencer has precedence). Same-cycle operations serialize
// port 0 before port 1. Responses arrive one cycle after the request.
module tas_lock_pair
    import tas_lock_pkg::*;
#(
    parameter int RETRY_GAP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_vld_i,
    input  logic [1:0] op_kind_i,
    output logic [1:0] rsp_vld_o,
    output logic [1:0] rsp_old_o,
    input  logic [1:0] seq_want_i,
    input  logic [1:0] seq_done_i,
    output logic [1:0] seq_busy_o,
    output logic [1:0] seq_crit_o,
    output logic       lock_o
);
    logic [NPORT-1:0] core_vld;
    logic [NPORT-1:0] core_kind;
    logic [NPORT-1:0] core_rsp_vld;
    logic [NPORT-1:0] core_rsp_old;
    logic [NPORT-1:0] seq_op_vld;
    logic [NPORT-1:0] seq_op_kind;
    logic [NPORT-1:0] seq_rsp_vld;
    logic [NPORT-1:0] seq_rsp_old;

    tas_lock_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (core_vld),
        .req_kind (core_kind),
        .lock_o   (lock_o),
        .rsp_vld  (core_rsp_vld),
        .rsp_old  (core_rsp_old)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        tas_lock_seq #(
            .RETRY_GAP (RETRY_GAP)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_i    (seq_want_i[p]),
            .done_i    (seq_done_i[p]),
            .rsp_vld_i (seq_rsp_vld[p]),
            .rsp_old_i (seq_rsp_old[p]),
            .op_vld_o  (seq_op_vld[p]),
            .op_kind_o (seq_op_kind[p]),
            .busy_o    (seq_busy_o[p]),
            .crit_o    (seq_crit_o[p])
        );

        tas_lock_portsel u_sel (
            .clk          (clk),
            .rst_n        (rst_n),
            .dir_vld      (op_vld_i[p]),
            .dir_kind     (op_kind_i[p]),
            .seq_vld      (seq_op_vld[p]),
            .seq_kind     (seq_op_kind[p]),
            .core_rsp_vld (core_rsp_vld[p]),
            .core_rsp_old (core_rsp_old[p]),
            .core_vld     (core_vld[p]),
            .core_kind    (core_kind[p]),
            .rsp_vld_o    (rsp_vld_o[p]),
            .rsp_old_o    (rsp_old_o[p]),
            .seq_rsp_vld  (seq_rsp_vld[p]),
            .seq_rsp_old  (seq_rsp_old[p])
        );
    end
endmodule

// File: rtl/tas_lock_pair_chk.sv
// Property checker for tas_lock_pair, attached by bind below.
// Watches the serialized requests reaching the lock bit, the top-level
// responses and the sequencer status.
module tas_lock_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] core_vld,
    input logic [1:0] core_kind,
    input logic [1:0] core_rsp_old,
    input logic [1:0] op_vld_i,
    input logic [1:0] rsp_vld_o,
    input logic [1:0] seq_crit_o,
    input logic       lock_o
);
    AST_LAST_TAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld[1] && !core_kind[1]) |=> lock_o); // R2
    AST_LAST_CLR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld[1] && core_kind[1]) |=> !lock_o); // R3
    AST_SOLO_P0_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld == 2'b01) |=> (lock_o == !$past(core_kind[0]))); // R6
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld == 2'b00) |=> $stable(lock_o)); // R10
    AST_P0_SEES_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
        core_vld[0] |=> (core_rsp_old[0] == $past(lock_o))); // R6
    AST_P1_SEES_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld == 2'b11) |=> (core_rsp_old[1] == !$past(core_kind[0]))); // R6
    AST_RACE_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (core_vld == 2'b11 && core_kind == 2'b00 && !lock_o) |=> (core_rsp_old == 2'b10)); // R5
    AST_RSP0_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o[0] |-> $past(op_vld_i[0])); // R4
    AST_RSP1_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o[1] |-> $past(op_vld_i[1])); // R4
    AST_ONE_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seq_crit_o) <= 1); // R11
    AST_CRIT_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_crit_o) |-> lock_o); // R11
endmodule

bind tas_lock_pair tas_lock_pair_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_vld     (core_vld),
    .core_kind    (core_kind),
    .core_rsp_old (core_rsp_old),
    .op_vld_i     (op_vld_i),
    .rsp_vld_o    (rsp_vld_o),
    .seq_crit_o   (seq_crit_o),
    .lock_o       (lock_o)
);

// File: tb/test_tas_lock_pair.sv
// Directed bench: inputs change just after a falling edge, outputs are
// sampled at the next falling edge (one rising edge in between).
module test_tas_lock_pair;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 2;
    localparam int WDOG       = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] op_vld_i, op_kind_i, seq_want_i, seq_done_i;
    logic [1:0] rsp_vld_o, rsp_old_o, seq_busy_o, seq_crit_o;
    logic       lock_o;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tas_lock_pair #(.RETRY_GAP(GAP)) i_tas_lock_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_vld_i   (op_vld_i),
        .op_kind_i  (op_kind_i),
        .rsp_vld_o  (rsp_vld_o),
        .rsp_old_o  (rsp_old_o),
        .seq_want_i (seq_want_i),
        .seq_done_i (seq_done_i),
        .seq_busy_o (seq_busy_o),
        .seq_crit_o (seq_crit_o),
        .lock_o     (lock_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One-cycle direct operation on both ports; sample the response.
    task automatic dir_op(input logic [1:0] vld, input logic [1:0] kind);
        op_vld_i  = vld;
        op_kind_i = kind;
        step();
        op_vld_i  = 2'b00;
        op_kind_i = 2'b00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_vld_i = '0; op_kind_i = '0; seq_want_i = '0; seq_done_i = '0;
        repeat (3) step();
        chk("R1 lock", {7'd0, lock_o}, 8'd0);
        chk("R1 rsp_vld", {6'd0, rsp_vld_o}, 8'd0);
        chk("R1 busy", {6'd0, seq_busy_o}, 8'd0);
        chk("R1 crit", {6'd0, seq_crit_o}, 8'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_single();
        dir_op(2'b01, 2'b00);
        chk("R4 pulse p0", {6'd0, rsp_vld_o}, 8'd1);
        chk("R2 old free", {7'd0, rsp_old_o[0]}, 8'd0);
        chk("R2 lock set", {7'd0, lock_o}, 8'd1);
        step();
        chk("R4 pulse ends", {6'd0, rsp_vld_o}, 8'd0);
        dir_op(2'b10, 2'b00);
        chk("R2 old held", {7'd0, rsp_old_o[1]}, 8'd1);
        chk("R2 lock stays", {7'd0, lock_o}, 8'd1);
        dir_op(2'b10, 2'b10);
        chk("R3 clear old", {7'd0, rsp_old_o[1]}, 8'd1);
        chk("R3 lock free", {7'd0, lock_o}, 8'd0);
        dir_op(2'b01, 2'b01);
        chk("R3 clear free old", {7'd0, rsp_old_o[0]}, 8'd0);
        chk("R3 lock still free", {7'd0, lock_o}, 8'd0);
    endtask

    task automatic t_race();
        dir_op(2'b11, 2'b00);
        chk("R5 valids", {6'd0, rsp_vld_o}, 8'd3);
        chk("R5 one winner", {6'd0, rsp_old_o}, 8'h2);
        chk("R5 lock", {7'd0, lock_o}, 8'd1);
        dir_op(2'b11, 2'b00);
        chk("R5 both lose held", {6'd0, rsp_old_o}, 8'h3);
        dir_op(2'b01, 2'b01);
    endtask

    task automatic t_mixed();
        dir_op(2'b01, 2'b00);
        dir_op(2'b11, 2'b01);
        chk("R6 clr then tas old", {6'd0, rsp_old_o}, 8'h1);
        chk("R6 clr then tas lock", {7'd0, lock_o}, 8'd1);
        dir_op(2'b11, 2'b10);
        chk("R6 tas then clr old", {6'd0, rsp_old_o}, 8'h3);
        chk("R6 tas then clr lock", {7'd0, lock_o}, 8'd0);
        dir_op(2'b11, 2'b10);
        chk("R6 free tas then clr old", {6'd0, rsp_old_o}, 8'h2);
        chk("R6 free tas then clr lock", {7'd0, lock_o}, 8'd0);
    endtask

    task automatic t_acquire_release();
        seq_want_i = 2'b01;
        step();
        seq_want_i = 2'b00;
        chk("R7 busy", {6'd0, seq_busy_o}, 8'd1);
        chk("R7 not yet crit", {6'd0, seq_crit_o}, 8'd0);
        step();
        chk("R7 still not crit", {6'd0, seq_crit_o}, 8'd0);
        step();
        chk("R7 crit", {6'd0, seq_crit_o}, 8'd1);
        chk("R7 lock", {7'd0, lock_o}, 8'd1);
        chk("R7 no direct rsp", {6'd0, rsp_vld_o}, 8'd0);
        seq_done_i = 2'b01;
        step();
        seq_done_i = 2'b00;
        chk("R9 crit drops", {6'd0, seq_crit_o}, 8'd0);
        chk("R9 lock held one more", {7'd0, lock_o}, 8'd1);
        step();
        chk("R9 lock free", {7'd0, lock_o}, 8'd0);
        chk("R9 idle", {6'd0, seq_busy_o}, 8'd0);
    endtask

    task automatic t_retry_and_share();
        int waited;
        dir_op(2'b10, 2'b00);
        seq_want_i = 2'b01;
        step();
        seq_want_i = 2'b00;
        // Sequencer 0 is in its attempt cycle: a direct clear is ignored.
        op_vld_i = 2'b01; op_kind_i = 2'b01;
        step();
        op_vld_i = 2'b00; op_kind_i = 2'b00;
        chk("R10 no rsp", {6'd0, rsp_vld_o}, 8'd0);
        chk("R10 lock kept", {7'd0, lock_o}, 8'd1);
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R8 still trying", {6'd0, seq_busy_o, seq_crit_o}, 8'h4);
        end
        dir_op(2'b10, 2'b10);
        waited = 0;
        while (!seq_crit_o[0] && waited < GAP + 3) begin
            step();
            waited++;
        end
        chk("R8 crit after free", {7'd0, seq_crit_o[0]}, 8'd1);
        chk("R8 lock taken", {7'd0, lock_o}, 8'd1);
        seq_done_i = 2'b01;
        step();
        seq_done_i = 2'b00;
        step();
        chk("R9 released", {7'd0, lock_o}, 8'd0);
    endtask

    task automatic t_contention();
        int waited;
        logic both;
        seq_want_i = 2'b11;
        step();
        seq_want_i = 2'b00;
        step();
        step();
        chk("R11 port0 wins", {6'd0, seq_crit_o}, 8'd1);
        chk("R11 port1 waits", {6'd0, seq_busy_o}, 8'd3);
        seq_done_i = 2'b01;
        step();
        seq_done_i = 2'b00;
        both = 1'b0;
        waited = 0;
        while (!seq_crit_o[1] && waited < 12) begin
            step();
            waited++;
            if (seq_crit_o == 2'b11) both = 1'b1;
        end
        chk("R11 never both", {7'd0, both}, 8'd0);
        chk("R11 port1 enters", {6'd0, seq_crit_o}, 8'd2);
        seq_done_i = 2'b10;
        step();
        seq_done_i = 2'b00;
        step();
        chk("R11 all idle", {5'd0, seq_busy_o, lock_o}, 8'd0);
    endtask

    task automatic t_reset_midway();
        seq_want_i = 2'b10;
        step();
        seq_want_i = 2'b00;
        step();
        step();
        chk("R1 setup crit", {6'd0, seq_crit_o}, 8'd2);
        rst_n = 1'b0;
        step();
        chk("R1 mid lock", {7'd0, lock_o}, 8'd0);
        chk("R1 mid status", {4'd0, seq_busy_o, seq_crit_o}, 8'd0);
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        rst_n = 1'b0;
        op_vld_i = '0; op_kind_i = '0; seq_want_i = '0; seq_done_i = '0;
        step();
        t_reset();
        t_single();
        t_race();
        t_mixed();
        t_acquire_release();
        t_retry_and_share();
        t_contention();
        t_reset_midway();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule